// File: doc/BRIEF.md
# Split-Slice Associative Tag Lookup

This block is the tag-lookup engine of one highly associative cache macro-block. Its entries form a grid of `ROWS` rows by `COLS` columns (128 by 8, so 1024 entries by default), and a tag may be placed in any entry. Each stored tag is split in two. The low `CAM_BITS` bits (12) sit in content-addressable storage and are compared against the lookup key in every entry at once. The upper `TAG_BITS-CAM_BITS` bits sit in plain storage. They are only consulted for the entries whose low slice matched, and there they confirm or reject the candidate.

A lookup passes through two stages. The first stage registers the vector of slice candidates. The second stage checks the stored upper bits of every candidate, picks a winner and registers the response. Lookup requests and responses use valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While a response waits unaccepted, the whole pipeline holds, `req_ready` stays low and the response payload does not change. The maintenance ports (fill and invalidate) are plain single-cycle strobes that are always honoured. While either strobe is high, `req_ready` is low. A lookup therefore never enters the pipeline in the same cycle as a write.

Software must keep writes and lookups ordered. A write is visible to any lookup accepted after the write's clock edge. A write landing while a lookup is held in the pipeline under back-pressure may or may not be reflected in that lookup's result.

Top module: `tlk_split_lookup`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low and `req_ready` is high, so the first lookup of any tag reports a miss.
- R2: A fill writes the slice, the upper bits and the valid bit of entry (`fill_row`, `fill_col`) on one clock edge. A lookup accepted on the very next edge with the same tag hits and reports that row and column.
- R3: A hit requires both the low 12-bit slice and the upper tag bits to match. A key whose slice matches a valid entry but whose upper bits differ reports a miss.
- R4: Every entry whose slice matches is checked. If several entries share the key's slice, the one whose upper bits also match is reported, even when other candidates have lower indices.
- R5: If more than one valid entry holds the full key, the lowest row wins, and within that row the lowest column wins.
- R6: An entry with a clear valid bit never matches. After an invalidate of (`inv_row`, `inv_col`), a lookup of its old tag misses. When a fill and an invalidate name the same entry in one cycle, the entry ends invalid.
- R7: A request accepted on edge k produces `rsp_valid` high after edge k+1, provided the response was not held by back-pressure.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_valid`, `rsp_hit`, `rsp_row` and `rsp_col` stay unchanged.
- R9: `req_ready` is low in every cycle in which `fill_en` or `inv_en` is high.
- R10: A miss response has `rsp_hit` = 0, `rsp_row` = 0 and `rsp_col` = 0. A hit response has `rsp_hit` = 1.
- R11: A second fill to an occupied entry replaces its tag. The old tag then misses and the new tag hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_tag | input | TAG_BITS | Full tag to look up |
| fill_en | input | 1 | Write a tag and set the valid bit this cycle |
| fill_row | input | $clog2(ROWS) | Row of the entry to fill |
| fill_col | input | $clog2(COLS) | Column of the entry to fill |
| fill_tag | input | TAG_BITS | Tag to store |
| inv_en | input | 1 | Clear the valid bit this cycle |
| inv_row | input | $clog2(ROWS) | Row of the entry to invalidate |
| inv_col | input | $clog2(COLS) | Column of the entry to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_row | output | $clog2(ROWS) | Row of the winning entry, 0 on miss |
| rsp_col | output | $clog2(COLS) | Column of the winning entry, 0 on miss |

## Verification
Directed lookups separate the two halves of the compare. One key matches a stored slice but not its upper bits, which tells a slice-only comparator from a full check. Several entries share one slice with different upper bits, which shows whether every candidate is examined or only the first. Duplicate full tags placed out of order check the row-then-column preference. A random phase then draws tags from a small slice and upper-bit space, so that slice collisions, refills and invalidates are dense. Each result is compared against a behavioural grid of tags held by the bench.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  // Result class of the second lookup stage.
  typedef enum logic [0:0] {
    LK_MISS = 1'b0,
    LK_HIT  = 1'b1
  } lk_result_e;
endpackage

// File: rtl/tlk_cam_slice.sv
// Associative store of the low tag slice plus the valid bit of each entry.
module tlk_cam_slice #(
  parameter int ENTRIES  = 1024,
  parameter int CAM_BITS = 12,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    fill_idx,
  input  logic [CAM_BITS-1:0] fill_slice,
  input  logic                inv_en,
  input  logic [IDX_W-1:0]    inv_idx,
  input  logic [CAM_BITS-1:0] key_slice,
  output logic [ENTRIES-1:0]  valid_o,
  output logic [ENTRIES-1:0]  match_o
);
  logic [CAM_BITS-1:0] slice_q [ENTRIES];
  logic [ENTRIES-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (fill_en) slice_q[fill_idx] <= fill_slice;
  end

  // Invalidate is applied after fill so it wins on a shared entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (fill_en) vld_q[fill_idx] <= 1'b1;
      if (inv_en)  vld_q[inv_idx]  <= 1'b0;
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_o[e] = vld_q[e] && (slice_q[e] == key_slice);
    end
  endgenerate

  assign valid_o = vld_q;
endmodule

// File: rtl/tlk_tag_ram.sv
// Plain storage of the upper tag bits, consulted only for slice candidates.
module tlk_tag_ram #(
  parameter int ENTRIES  = 1024,
  parameter int REM_BITS = 12,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    fill_idx,
  input  logic [REM_BITS-1:0] fill_rem,
  input  logic [ENTRIES-1:0]  cand_i,
  input  logic [REM_BITS-1:0] key_rem,
  output logic [ENTRIES-1:0]  confirm_o
);
  logic [REM_BITS-1:0] rem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (fill_en) rem_q[fill_idx] <= fill_rem;
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
      assign confirm_o[e] = cand_i[e] && (rem_q[e] == key_rem);
    end
  endgenerate
endmodule

// File: rtl/tlk_prio_pick.sv
// Lowest set index of a vector (row-major order gives row first, then column).
module tlk_prio_pick #(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (vec_i[e]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/tlk_split_lookup.sv
module tlk_split_lookup #(
  parameter int ROWS     = 128,
  parameter int COLS     = 8,
  parameter int CAM_BITS = 12,
  parameter int TAG_BITS = 24,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int ENTRIES = ROWS * COLS,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int REM_BITS = TAG_BITS - CAM_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TAG_BITS-1:0] req_tag,
  input  logic                fill_en,
  input  logic [ROW_W-1:0]    fill_row,
  input  logic [COL_W-1:0]    fill_col,
  input  logic [TAG_BITS-1:0] fill_tag,
  input  logic                inv_en,
  input  logic [ROW_W-1:0]    inv_row,
  input  logic [COL_W-1:0]    inv_col,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic [ROW_W-1:0]    rsp_row,
  output logic [COL_W-1:0]    rsp_col
);
  import tlk_pkg::*;

  logic [IDX_W-1:0]   fill_idx, inv_idx, pick_idx;
  logic [ENTRIES-1:0] cur_valid, slice_match, s2_cand, s2_confirm;
  logic               adv, accept, pick_any;
  lk_result_e         pick_res;

  // Stage-1 registers
  logic                s1_vld;
  logic [REM_BITS-1:0] s1_rem;
  logic [ENTRIES-1:0]  s1_cand;

  assign fill_idx = IDX_W'(fill_row) * IDX_W'(COLS) + IDX_W'(fill_col);
  assign inv_idx  = IDX_W'(inv_row)  * IDX_W'(COLS) + IDX_W'(inv_col);

  // Pipeline moves unless a finished response is being held.
  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv && !fill_en && !inv_en;
  assign accept    = req_valid && req_ready;

  tlk_cam_slice #(.ENTRIES(ENTRIES), .CAM_BITS(CAM_BITS)) cam_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_slice (fill_tag[CAM_BITS-1:0]),
    .inv_en     (inv_en),
    .inv_idx    (inv_idx),
    .key_slice  (req_tag[CAM_BITS-1:0]),
    .valid_o    (cur_valid),
    .match_o    (slice_match)
  );

  // Candidates that lost their valid bit while held are dropped.
  assign s2_cand = s1_cand & cur_valid;

  tlk_tag_ram #(.ENTRIES(ENTRIES), .REM_BITS(REM_BITS)) ram_i (
    .clk       (clk),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_rem  (fill_tag[TAG_BITS-1:CAM_BITS]),
    .cand_i    (s2_cand),
    .key_rem   (s1_rem),
    .confirm_o (s2_confirm)
  );

  tlk_prio_pick #(.ENTRIES(ENTRIES)) pick_i (
    .vec_i (s2_confirm),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign pick_res = pick_any ? LK_HIT : LK_MISS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_rem    <= '0;
      s1_cand   <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_row   <= '0;
      rsp_col   <= '0;
    end else if (adv) begin
      s1_vld    <= accept;
      s1_rem    <= req_tag[TAG_BITS-1:CAM_BITS];
      s1_cand   <= slice_match;
      rsp_valid <= s1_vld;
      rsp_hit   <= (pick_res == LK_HIT);
      if (pick_res == LK_HIT) begin
        rsp_row <= ROW_W'(pick_idx / IDX_W'(COLS));
        rsp_col <= COL_W'(pick_idx % IDX_W'(COLS));
      end else begin
        rsp_row <= '0;
        rsp_col <= '0;
      end
    end
  end
endmodule

// File: rtl/tlk_split_lookup_chk.sv
module tlk_split_lookup_chk #(
  parameter int ROW_W = 7,
  parameter int COL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             fill_en,
  input logic             inv_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [ROW_W-1:0] rsp_row,
  input logic [COL_W-1:0] rsp_col,
  input logic             s1_vld
);
  // R8: a held response does not move.
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_row) && $stable(rsp_col)));

  // R8: no new request while a response is held.
  a_r8_hold_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9: maintenance strobes block lookups.
  a_r9_write_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en || inv_en) |-> !req_ready);

  // R10: miss carries zero coordinates.
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_row == '0 && rsp_col == '0));

  // R7: a response only appears behind an occupied first stage.
  a_r7_rsp_from_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(s1_vld));
endmodule

bind tlk_split_lookup tlk_split_lookup_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .fill_en   (fill_en),
  .inv_en    (inv_en),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_row   (rsp_row),
  .rsp_col   (rsp_col),
  .s1_vld    (s1_vld)
);

// File: tb/tlk_split_lookup_tb_top.sv
module tlk_split_lookup_tb_top;
  localparam int ROWS = 128, COLS = 8, CAM_BITS = 12, TAG_BITS = 24;
  localparam int N = ROWS * COLS;

  typedef struct packed {
    logic       hit;
    logic [6:0] row;
    logic [2:0] col;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [TAG_BITS-1:0] req_tag = '0;
  logic fill_en = 1'b0;
  logic [6:0] fill_row = '0;
  logic [2:0] fill_col = '0;
  logic [TAG_BITS-1:0] fill_tag = '0;
  logic inv_en = 1'b0;
  logic [6:0] inv_row = '0;
  logic [2:0] inv_col = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_hit;
  logic [6:0] rsp_row;
  logic [2:0] rsp_col;

  always #5 clk = ~clk;

  tlk_split_lookup #(.ROWS(ROWS), .COLS(COLS), .CAM_BITS(CAM_BITS), .TAG_BITS(TAG_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .fill_en(fill_en), .fill_row(fill_row), .fill_col(fill_col), .fill_tag(fill_tag),
    .inv_en(inv_en), .inv_row(inv_row), .inv_col(inv_col),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_row(rsp_row), .rsp_col(rsp_col)
  );

  // Behavioural tag grid
  logic                m_vld [N];
  logic [TAG_BITS-1:0] m_tag [N];
  exp_t exp_q [$];
  string tag_q [$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model_look(input logic [TAG_BITS-1:0] t);
    exp_t r = '0;
    for (int e = 0; e < N; e++) begin
      if (m_vld[e] && m_tag[e] == t) begin
        r.hit = 1'b1; r.row = 7'(e / COLS); r.col = 3'(e % COLS);
        return r;
      end
    end
    return r;
  endfunction

  // Monitor: pop expected items as responses transfer.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected response", 1, 0);
      end else begin
        exp_t e;
        string rq;
        e = exp_q.pop_front();
        rq = tag_q.pop_front();
        chk({rsp_hit, rsp_row, rsp_col} == e, rq, int'({rsp_hit, rsp_row, rsp_col}), int'(e));
      end
    end
  end

  task automatic do_fill(input int r, input int c, input logic [TAG_BITS-1:0] t);
    fill_en = 1'b1; fill_row = 7'(r); fill_col = 3'(c); fill_tag = t;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 req_ready during fill", int'(req_ready), 0);
    @(posedge clk); #1;
    fill_en = 1'b0;
    m_vld[r * COLS + c] = 1'b1;
    m_tag[r * COLS + c] = t;
  endtask

  task automatic do_inv(input int r, input int c);
    inv_en = 1'b1; inv_row = 7'(r); inv_col = 3'(c);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 req_ready during invalidate", int'(req_ready), 0);
    @(posedge clk); #1;
    inv_en = 1'b0;
    m_vld[r * COLS + c] = 1'b0;
  endtask

  task automatic do_look(input logic [TAG_BITS-1:0] t, input string req);
    bit acc;
    exp_q.push_back(model_look(t));
    tag_q.push_back(req);
    req_valid = 1'b1; req_tag = t;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int e = 0; e < N; e++) begin m_vld[e] = 1'b0; m_tag[e] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    @(posedge clk); #1;
    do_look(24'h000000, "R1 lookup after reset misses");
    do_look(24'hABC123, "R1 lookup after reset misses");
    drain();

    // R2: fill then lookup on the next edge
    do_fill(3, 4, 24'hABC123);
    do_look(24'hABC123, "R2 hit right after fill");
    drain();

    // R3: slice match with wrong upper bits
    do_look(24'h55C123, "R3 slice-only match misses");
    do_look(24'h000123, "R3 slice-only match misses");
    drain();

    // R4: several candidates share one slice
    do_fill(2, 1, 24'h111777);
    do_fill(5, 0, 24'h222777);
    do_fill(9, 6, 24'h333777);
    do_look(24'h333777, "R4 third candidate confirmed");
    do_look(24'h222777, "R4 second candidate confirmed");
    do_look(24'h444777, "R4 no candidate confirmed");
    drain();

    // R5: duplicate full tags
    do_fill(40, 0, 24'h5A5A5A);
    do_fill(10, 6, 24'h5A5A5A);
    do_fill(10, 2, 24'h5A5A5A);
    do_look(24'h5A5A5A, "R5 lowest row then column wins");
    drain();

    // R6: invalidate, and invalidate beats fill on one entry
    do_fill(7, 7, 24'hC0FFEE);
    do_look(24'hC0FFEE, "R6 hit before invalidate");
    do_inv(7, 7);
    do_look(24'hC0FFEE, "R6 miss after invalidate");
    fill_en = 1'b1; fill_row = 7'd9; fill_col = 3'd1; fill_tag = 24'hBEEF01;
    inv_en = 1'b1; inv_row = 7'd9; inv_col = 3'd1;
    @(posedge clk); #1;
    fill_en = 1'b0; inv_en = 1'b0;
    do_look(24'hBEEF01, "R6 same-cycle fill and invalidate leaves entry invalid");
    drain();

    // R11: overwrite
    do_fill(7, 7, 24'h123456);
    do_fill(7, 7, 24'h654456);
    do_look(24'h123456, "R11 old tag misses after overwrite");
    do_look(24'h654456, "R11 new tag hits after overwrite");
    drain();

    // R7: latency
    exp_q.push_back(model_look(24'hABC123));
    tag_q.push_back("R7 latency response");
    req_valid = 1'b1; req_tag = 24'hABC123;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 request accepted", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 no response one edge after accept", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 response two edges after accept", int'(rsp_valid), 1);
    drain();

    // R8: back-pressure
    rsp_ready = 1'b0;
    do_look(24'h5A5A5A, "R8 held response value");
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 response held", int'(rsp_valid), 1);
    chk(req_ready == 1'b0, "R8 req_ready low while held", int'(req_ready), 0);
    chk({rsp_hit, rsp_row, rsp_col} == {1'b1, 7'd10, 3'd2}, "R8 payload stable",
        int'({rsp_hit, rsp_row, rsp_col}), int'({1'b1, 7'd10, 3'd2}));
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    drain();

    // Random phase: dense slice collisions (R3, R4, R5, R6, R10, R11)
    for (int i = 0; i < 300; i++) begin
      logic [TAG_BITS-1:0] t;
      int op;
      t = {12'(32'h800 + $urandom_range(0, 3)), 12'(32'h900 + $urandom_range(0, 5))};
      op = $urandom_range(0, 9);
      if (op < 3) do_fill($urandom_range(0, 15), $urandom_range(0, 7), t);
      else if (op < 4) do_inv($urandom_range(0, 15), $urandom_range(0, 7));
      else do_look(t, "R4 R5 R10 random lookup");
    end
    drain();
    chk(exp_q.size() == 0, "R7 every request answered", exp_q.size(), 0);
    finish_run();
  end
endmodule